// File: doc/BRIEF.md
# Serial Flash Slave Interface with Pause Control

This block is the serial side of a flash memory slave. It samples the serial clock, chip select, pause and data-in pins with a fast system clock. It takes bits in on serial clock rising edges and moves its data-out bit on falling edges, so a master in either clock-idle-low or clock-idle-high operation can talk to it. Every complete opcode, address and write byte is reported to a command layer through a one-cycle valid strobe with a kind code and a 24-bit word.

A small byte-wide memory stub stands in for the array so that reads, writes and a busy period can be seen at the pins. The stub understands three opcodes: read, program and status.

An active-low pause input can freeze a transfer in mid-byte. A pause starts and ends only while the serial clock is low. Raising chip select during a pause wipes the transfer state.

Top module: `spi_flash_front`

## Requirements
- R1: After reset, so_en and rx_valid are 0 and the busy bit reads 0.
- R2: Bits are taken MSB first on serial clock rising edges, whichever level the clock idles at. The eighth bit after select completes the opcode, which is reported with rx_kind 0 and the opcode in rx_word[7:0].
- R3: After opcode 03h (read) or 02h (program), the next 24 bits form the address. Only the low 21 bits are kept (range 000000h to 1FFFFFh), and they are reported with rx_kind 1.
- R4: For a read, data leaves MSB first and changes on falling edges, with so_en high. Bytes come from consecutive addresses. The stub holds byte ((i*3+1) mod 256) at index i, where i is the address modulo 64.
- R5: For a program, each complete data byte is reported with rx_kind 2 and written at the current address, which then advances. When chip select rises after at least one byte was written, the busy bit is set for BUSY_CYCLES clock cycles.
- R6: Opcode 05h returns the status byte repeatedly, with busy in bit 0. The busy count keeps falling while a pause is active, and program bytes that arrive while busy leave the memory unchanged.
- R7: A pause starts when the pause input is low and the serial clock is low. If the pause input falls while the clock is high, the pause starts at the next falling edge, and that edge still moves the output.
- R8: A pause ends only when the pause input is high and the serial clock is low. Clock edges seen before that, including the falling edge that ends a deferred pause, are ignored.
- R9: During a pause, so_en is 0 and the data input and serial clock have no effect. Partial bytes and bit counts resume unchanged afterwards.
- R10: Chip select going high during a pause resets the interface. A selection that begins while the pause input is low is ignored in full.
- R11: Chip select going high ends the command at any point and drops any incomplete byte. so_en is 0 while deselected.
- R12: An opcode other than 02h, 03h and 05h is reported, and the rest of that selection is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause request, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for the data-out pad |
| rx_valid | output | 1 | One-cycle strobe for a completed field |
| rx_kind | output | 2 | 0 opcode, 1 address, 2 write data |
| rx_word | output | 24 | Opcode or data byte in bits 7:0, or the 21-bit address |

## Verification
A bit counter or phase that slips shows at the pins within the same byte. Read data then comes out rotated, or an event has the wrong kind or value. The scoreboard catches this on the strobe, and the read checks catch it one bit later. A pause that is entered or left on the wrong clock level shifts the read stream by one bit right after the pause, so the next sampled byte gives it away. A busy counter that stalls, or a write that ignores busy, shows in the next status or read-back byte.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int ADDR_BITS   = 21,
  parameter int MEM_BYTES   = 64,
  parameter int BUSY_CYCLES = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        hold_n,
  input  logic        si,
  output logic        so,
  output logic        so_en,
  output logic        rx_valid,
  output logic [1:0]  rx_kind,
  output logic [23:0] rx_word
);
  localparam int MW = $clog2(MEM_BYTES);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_STAT = 8'h05;

  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_WR, PH_OUT, PH_IGN} phase_t;

  logic [SYNC_STAGES-1:0] sclk_q, cs_q, hold_q, si_q;
  logic s_sclk, s_cs, s_hold, s_si, p_sclk, p_cs;
  logic act, held, prog_wr, so_q;
  phase_t phase;
  logic [7:0] cmd, txsh;
  logic [4:0] bitc;
  logic [ADDR_BITS-2:0] sh;
  logic [ADDR_BITS-1:0] sh_nx, ptr;
  logic [BW-1:0] busy_cnt;
  logic [7:0] mem [MEM_BYTES];
  logic [31:0] busy_w;
  logic [MW-1:0] nxt_idx;
  logic [7:0] status;
  logic rise, fall, cs_rise, cs_fall, go_rise, go_fall;

  assign s_sclk  = sclk_q[SYNC_STAGES-1];
  assign s_cs    = cs_q[SYNC_STAGES-1];
  assign s_hold  = hold_q[SYNC_STAGES-1];
  assign s_si    = si_q[SYNC_STAGES-1];
  assign rise    = s_sclk & ~p_sclk;
  assign fall    = ~s_sclk & p_sclk;
  assign cs_rise = s_cs & ~p_cs;
  assign cs_fall = ~s_cs & p_cs;
  assign go_rise = act & ~held & rise;
  assign go_fall = act & ~held & fall;
  assign sh_nx   = {sh, s_si};
  assign nxt_idx = ptr[MW-1:0] + 1'b1;
  assign status  = {7'b0, busy_cnt != '0};
  assign busy_w  = 32'(busy_cnt);
  assign so      = so_q;
  assign so_en   = act & ~held & (phase == PH_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0; cs_q <= '1; hold_q <= '1; si_q <= '0;
      p_sclk <= 1'b0; p_cs <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
      hold_q <= {hold_q[SYNC_STAGES-2:0], hold_n};
      si_q   <= {si_q[SYNC_STAGES-2:0], si};
      p_sclk <= s_sclk;
      p_cs   <= s_cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; held <= 1'b0; prog_wr <= 1'b0; so_q <= 1'b0;
      phase <= PH_OP; cmd <= '0; txsh <= '0; bitc <= '0; sh <= '0; ptr <= '0;
      busy_cnt <= '0; rx_valid <= 1'b0; rx_kind <= '0; rx_word <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'(i * 3 + 1);
    end else begin
      rx_valid <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (s_cs) begin
        act <= 1'b0; held <= 1'b0; phase <= PH_OP; bitc <= '0; so_q <= 1'b0;
        prog_wr <= 1'b0;
        if (cs_rise && prog_wr && busy_cnt == '0) busy_cnt <= BW'(BUSY_CYCLES);
      end else begin
        if (cs_fall && s_hold) act <= 1'b1;
        if (act) begin
          if (!held && !s_hold && !s_sclk) held <= 1'b1;
          else if (held && s_hold && !s_sclk) held <= 1'b0;
        end
        if (go_rise) begin
          case (phase)
            PH_OP: begin
              sh <= sh_nx[ADDR_BITS-2:0];
              bitc <= bitc + 1'b1;
              if (bitc == 5'd7) begin
                bitc <= '0;
                cmd <= sh_nx[7:0];
                rx_valid <= 1'b1; rx_kind <= 2'd0; rx_word <= {16'h0, sh_nx[7:0]};
                case (sh_nx[7:0])
                  OP_READ, OP_PROG: phase <= PH_ADDR;
                  OP_STAT: begin phase <= PH_OUT; txsh <= status; end
                  default: phase <= PH_IGN;
                endcase
              end
            end
            PH_ADDR: begin
              sh <= sh_nx[ADDR_BITS-2:0];
              bitc <= bitc + 1'b1;
              if (bitc == 5'd23) begin
                bitc <= '0;
                ptr <= sh_nx;
                rx_valid <= 1'b1; rx_kind <= 2'd1; rx_word <= 24'(sh_nx);
                if (cmd == OP_READ) begin
                  phase <= PH_OUT;
                  txsh <= mem[sh_nx[MW-1:0]];
                end else phase <= PH_WR;
              end
            end
            PH_WR: begin
              sh <= sh_nx[ADDR_BITS-2:0];
              bitc <= bitc + 1'b1;
              if (bitc == 5'd7) begin
                bitc <= '0;
                ptr <= ptr + 1'b1;
                rx_valid <= 1'b1; rx_kind <= 2'd2; rx_word <= {16'h0, sh_nx[7:0]};
                if (busy_cnt == '0) begin
                  mem[ptr[MW-1:0]] <= sh_nx[7:0];
                  prog_wr <= 1'b1;
                end
              end
            end
            default: ;
          endcase
        end
        if (go_fall && phase == PH_OUT) begin
          so_q <= txsh[7];
          bitc <= bitc + 1'b1;
          if (bitc == 5'd7) begin
            bitc <= '0;
            if (cmd == OP_READ) begin
              txsh <= mem[nxt_idx];
              ptr <= ptr + 1'b1;
            end else txsh <= status;
          end else txsh <= {txsh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_cs,
  input logic        s_hold,
  input logic        s_sclk,
  input logic        held,
  input logic        so_en,
  input logic        rx_valid,
  input logic [31:0] busy_w
);
  a_r6_busy_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w != 0 |=> busy_w == $past(busy_w) - 1);
  a_r9_no_event_held: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !rx_valid);
  a_r7_entry_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(!s_sclk && !s_hold));
  a_r8_exit_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (held && s_sclk && !s_cs) |=> held);
  a_r10_cs_clears_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> !held);
  a_r11_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> !so_en);
endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .s_hold(s_hold), .s_sclk(s_sclk),
  .held(held), .so_en(so_en), .rx_valid(rx_valid), .busy_w(busy_w)
);

// File: tb/spi_flash_front_test.sv
module spi_flash_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic so, so_en, rx_valid;
  logic [1:0] rx_kind;
  logic [23:0] rx_word;
  int n_tests = 0, n_fail = 0, m_tests = 0, m_fail = 0, cyc = 0;
  bit m3 = 1'b0, done = 1'b0;

  typedef struct packed { logic [1:0] k; logic [23:0] w; } ev_t;
  ev_t exp_q[$];

  spi_flash_front uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .hold_n(hold_n),
    .si(si), .so(so), .so_en(so_en), .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_word(rx_word));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid) begin
      m_tests++;
      if (exp_q.size() == 0) begin
        m_fail++;
        $display("FAIL R11 unexpected event kind %0d word %h, expected none", rx_kind, rx_word);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        if (e.k != rx_kind || e.w != rx_word) begin
          m_fail++;
          $display("FAIL %s event: got kind %0d word %h, expected kind %0d word %h",
            e.k == 0 ? "R2" : (e.k == 1 ? "R3" : "R5"), rx_kind, rx_word, e.k, e.w);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      $display("FAIL watchdog: run did not finish, expected end before 150000 cycles");
      $display("[TB] %0d tests run, %0d failed", n_tests + m_tests + 1, n_fail + m_fail + 1);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [23:0] w);
    exp_q.push_back({k, w});
  endtask

  task automatic sel();
    sclk = m3; tick(8); cs_n = 1'b0; tick(8);
  endtask

  task automatic desel();
    if (!m3) sclk = 1'b0;
    tick(8); cs_n = 1'b1; tick(12);
  endtask

  task automatic bit_out(input logic v);
    sclk = 1'b0; si = v; tick(8); sclk = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic send_addr(input logic [23:0] a);
    for (int i = 23; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic read_bit(output logic v);
    sclk = 1'b0; tick(8); v = so; sclk = 1'b1; tick(8);
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) read_bit(b[i]);
  endtask

  function automatic logic [7:0] stub(input int a);
    return 8'(((a % 64) * 3) + 1);
  endfunction

  initial begin
    logic [7:0] b;
    logic v;
    tick(4); rst_n = 1'b1; tick(4);
    chk(so_en == 0, "R1 so_en after reset", 32'(so_en), 0);
    chk(rx_valid == 0, "R1 rx_valid after reset", 32'(rx_valid), 0);

    // R1 busy clear, R6 status opcode
    sel(); expect_ev(0, 24'h05); send_byte(8'h05); read_byte(b); desel();
    chk(b == 8'h00, "R1 status after reset", 32'(b), 0);

    // R2 R3 R4 mode 0 read
    sel(); expect_ev(0, 24'h03); send_byte(8'h03); expect_ev(1, 24'h000005); send_addr(24'h000005);
    chk(so_en == 1, "R4 so_en during read", 32'(so_en), 1);
    for (int i = 0; i < 3; i++) begin
      read_byte(b);
      chk(b == stub(5 + i), "R4 read data", 32'(b), 32'(stub(5 + i)));
    end
    desel();

    // R2 R3 mode 3 read, top address bits dropped
    m3 = 1'b1;
    sel(); expect_ev(0, 24'h03); send_byte(8'h03); expect_ev(1, 24'h1FFFF0); send_addr(24'hFFFFF0);
    read_byte(b); chk(b == 8'h91, "R3 masked address data", 32'(b), 32'h91);
    read_byte(b); chk(b == 8'h94, "R4 mode 3 next byte", 32'(b), 32'h94);
    desel();
    chk(so_en == 0, "R11 so_en deselected", 32'(so_en), 0);
    m3 = 1'b0;

    // R5 program, then R6 write while busy is dropped
    sel(); expect_ev(0, 24'h02); send_byte(8'h02); expect_ev(1, 24'h000010); send_addr(24'h000010);
    expect_ev(2, 24'h5A); send_byte(8'h5A); expect_ev(2, 24'hC3); send_byte(8'hC3); desel();
    sel(); expect_ev(0, 24'h02); send_byte(8'h02); expect_ev(1, 24'h000010); send_addr(24'h000010);
    expect_ev(2, 24'hFF); send_byte(8'hFF); desel();

    // R6 busy keeps counting during a pause
    sel(); expect_ev(0, 24'h05); send_byte(8'h05); read_byte(b);
    chk(b == 8'h01, "R5 busy after program", 32'(b), 1);
    sclk = 1'b0; tick(8); hold_n = 1'b0; tick(2000);
    chk(so_en == 0, "R9 so_en off in pause", 32'(so_en), 0);
    hold_n = 1'b1; tick(8);
    read_byte(b); chk(b == 8'h01, "R6 preloaded status byte", 32'(b), 1);
    read_byte(b); chk(b == 8'h00, "R6 busy ended during pause", 32'(b), 0);
    desel();

    sel(); expect_ev(0, 24'h03); send_byte(8'h03); expect_ev(1, 24'h000010); send_addr(24'h000010);
    read_byte(b); chk(b == 8'h5A, "R5 written byte 0", 32'(b), 32'h5A);
    read_byte(b); chk(b == 8'hC3, "R6 busy write ignored", 32'(b), 32'hC3);
    read_byte(b); chk(b == stub(18), "R5 untouched neighbour", 32'(b), 32'(stub(18)));
    desel();

    // R7 R9 immediate pause inside the opcode
    sel(); expect_ev(0, 24'h03);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    sclk = 1'b0; tick(8); hold_n = 1'b0; tick(8);
    for (int i = 0; i < 2; i++) begin si = 1'b1; sclk = 1'b1; tick(8); sclk = 1'b0; tick(8); end
    hold_n = 1'b1; tick(8);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    expect_ev(1, 24'h000020); send_addr(24'h000020);
    read_byte(b); chk(b == stub(32), "R9 frozen opcode resumes", 32'(b), 32'(stub(32)));
    desel();

    // R7 R8 deferred entry and exit in the read stream
    sel(); expect_ev(0, 24'h03); send_byte(8'h03); expect_ev(1, 24'h00000B); send_addr(24'h00000B);
    for (int i = 7; i >= 4; i--) begin read_bit(v); b[i] = v; end
    hold_n = 1'b0; tick(8);
    sclk = 1'b0; tick(8);
    chk(so_en == 0, "R7 pause began at falling edge", 32'(so_en), 0);
    sclk = 1'b1; tick(8); hold_n = 1'b1; tick(8);
    chk(so_en == 0, "R8 exit waits for clock low", 32'(so_en), 0);
    sclk = 1'b0; tick(8);
    chk(so_en == 1, "R8 exit at clock low", 32'(so_en), 1);
    for (int i = 3; i >= 0; i--) begin read_bit(v); b[i] = v; end
    chk(b == stub(11), "R8 byte across pause", 32'(b), 32'(stub(11)));
    read_byte(b); chk(b == stub(12), "R7 following byte", 32'(b), 32'(stub(12)));
    desel();

    // R10 deselect during pause resets; select while paused is ignored
    sel();
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    sclk = 1'b0; tick(8); hold_n = 1'b0; tick(8);
    cs_n = 1'b1; tick(16); cs_n = 1'b0; tick(8);
    send_byte(8'h05);
    chk(so_en == 0, "R10 selection while paused ignored", 32'(so_en), 0);
    desel(); hold_n = 1'b1; tick(8);
    sel(); expect_ev(0, 24'h05); send_byte(8'h05); read_byte(b); desel();
    chk(b == 8'h00, "R10 clean restart", 32'(b), 0);

    // R11 partial fields dropped
    sel(); expect_ev(0, 24'h03); send_byte(8'h03);
    for (int i = 0; i < 12; i++) bit_out(1'b1);
    desel();
    sel(); for (int i = 0; i < 5; i++) bit_out(1'b1); desel();
    sel(); expect_ev(0, 24'h03); send_byte(8'h03); expect_ev(1, 24'h000000); send_addr(24'h000000);
    read_byte(b); chk(b == stub(0), "R11 command after abort", 32'(b), 32'(stub(0)));
    desel();

    // R12 unknown opcode
    sel(); expect_ev(0, 24'h9F); send_byte(8'h9F); send_byte(8'hAA);
    chk(so_en == 0, "R12 unknown opcode silent", 32'(so_en), 0);
    desel();

    tick(20);
    chk(exp_q.size() == 0, "R2 all expected events seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests + m_tests, n_fail + m_fail);
    $finish;
  end
endmodule